// File: doc/BRIEF.md
# Sequential Shift-Subtract Integer Divider

This block divides a double-width dividend by a single-width divisor over a fixed number of clock cycles. With the default parameters it takes a 32-bit dividend and a 16-bit divisor and returns a 16-bit quotient and a 16-bit remainder. One engine serves unsigned and two's-complement division, and it works in byte or word mode. The mode sets the range the quotient must fit. A processor datapath uses it for its divide instructions. It also uses it for the adjust step that splits an 8-bit binary value into decimal digits. For that step the caller supplies the value zero-extended, divides by ten, and takes the low bytes of quotient and remainder.

A one-cycle start pulse captures the operands and the mode inputs. The engine then works on magnitudes and retires one quotient bit per clock. In a final cycle it applies the signs and checks the range. A one-cycle done pulse marks the moment when quotient, remainder and the overflow flag are valid. These outputs then hold until the next completion. A zero divisor is reported through the same overflow flag as a quotient that does not fit. When the flag is set, the quotient and remainder carry no meaning.

Top module: `seq_divider`

## Requirements
- R1: While reset is asserted, and after it is released until the first completion, done_o, overflow_o, quotient_o and remainder_o are all zero.
- R2: The done pulse is a single cycle. When start_i is sampled high on a rising edge while the block is idle, done_o rises after the 17th following rising edge. With the default width that is one edge per quotient bit plus one for sign correction.
- R3: With signed_i=0, the quotient is the floor of dividend/divisor and the remainder is dividend mod divisor, both treated as unsigned. This includes the decimal-split use: an 8-bit value zero-extended, divided by 10 in byte mode.
- R4: With signed_i=1, the operands are read as two's complement and the quotient truncates toward zero. The remainder is zero or takes the sign of the dividend, and |remainder| < |divisor|.
- R5: With word_i=0 (byte mode), bits 15:8 of divisor_i are ignored. The divisor is taken from bits 7:0, sign-extended from bit 7 when signed_i=1 and zero-extended otherwise. The dividend is always used at its full width.
- R6: A divisor that is zero after the R5 extension sets overflow_o on the done pulse.
- R7: overflow_o is set on the done pulse when the true quotient falls outside the selected range. The ranges are: unsigned byte 0..255, unsigned word 0..65535, signed byte -128..127, signed word -32768..32767. Quotients at the range ends do not overflow.
- R8: A start pulse that arrives while an operation is in progress is ignored. It causes no extra done pulse and does not change the result of the running operation.
- R9: Operands and mode inputs are captured at the accepting edge. Their later changes do not affect the result. quotient_o, remainder_o and overflow_o hold their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | One-cycle request to begin a division |
| signed_i | input | 1 | 1 = two's-complement division, 0 = unsigned |
| word_i | input | 1 | 1 = word mode, 0 = byte mode |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 16 | Divisor; only bits 7:0 are used in byte mode |
| quotient_o | output | 16 | Quotient, valid on done_o |
| remainder_o | output | 16 | Remainder, valid on done_o |
| overflow_o | output | 1 | Zero divisor or quotient out of range, valid on done_o |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties check several things on every cycle:
- done never lasts two cycles, and it always follows the correction state;
- the iteration counter steps by one;
- a zero divisor always yields overflow;
- an in-range unsigned byte quotient has a clear upper byte;
- a nonzero signed remainder carries the dividend's sign;
- a start during an operation leaves the captured mode untouched.

The arithmetic values themselves, the exact 17-cycle latency, the range limits at their boundaries, the ignored upper divisor byte and the holding of results after operands change can only be shown by the bench's scenarios. There a behavioural model with 64-bit integer division is compared against the outputs on every clock.

// File: rtl/seq_div_pkg.sv
package seq_div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

endpackage

// File: rtl/seq_div_prep.sv
// Operand preparation: byte-mode divisor extension, magnitudes, signs and
// the checks that can be decided before any iteration.
module seq_div_prep #(
  parameter int QW = 16,
  parameter int SW = 8
) (
  input  logic            signed_i,
  input  logic            word_i,
  input  logic [2*QW-1:0] dividend_i,
  input  logic [QW-1:0]   divisor_i,
  output logic [2*QW-1:0] dvd_mag_o,
  output logic [QW-1:0]   dvs_mag_o,
  output logic            dvd_neg_o,
  output logic            dvs_neg_o,
  output logic            dvs_zero_o,
  output logic            hi_ovf_o
);

  localparam int DW = 2 * QW;

  logic [QW-1:0] dvs_short_ext;
  logic [QW-1:0] dvs_ext;

  generate
    if (SW < QW) begin : g_short_ext
      always_comb begin
        dvs_short_ext = {{(QW-SW){signed_i & divisor_i[SW-1]}}, divisor_i[SW-1:0]};
      end
    end else begin : g_no_ext
      always_comb begin
        dvs_short_ext = divisor_i;
      end
    end
  endgenerate

  always_comb begin
    dvs_ext    = word_i ? divisor_i : dvs_short_ext;
    dvd_neg_o  = signed_i & dividend_i[DW-1];
    dvs_neg_o  = signed_i & dvs_ext[QW-1];
    dvd_mag_o  = dvd_neg_o ? (~dividend_i + 1'b1) : dividend_i;
    dvs_mag_o  = dvs_neg_o ? (~dvs_ext + 1'b1) : dvs_ext;
    dvs_zero_o = (dvs_ext == '0);
    // A high half not below the divisor means a quotient wider than QW bits.
    hi_ovf_o   = (dvd_mag_o[DW-1:QW] >= dvs_mag_o);
  end

endmodule

// File: rtl/seq_div_core.sv
// Restoring shift-subtract engine on magnitudes, one quotient bit per step.
module seq_div_core #(
  parameter int QW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [2*QW-1:0] dvd_mag_i,
  input  logic [QW-1:0]   dvs_mag_i,
  output logic [QW-1:0]   quo_mag_o,
  output logic [QW-1:0]   rem_mag_o,
  output logic            last_o
);

  localparam int DW = 2 * QW;
  localparam int CW = (QW > 1) ? $clog2(QW) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(QW - 1);

  logic [QW-1:0] rem_q, rem_d;
  logic [QW-1:0] shf_q, shf_d;
  logic [QW-1:0] dvs_q, dvs_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          reg_en;

  logic [QW:0]   trial;
  logic [QW+1:0] diff;
  logic          fits;

  always_comb begin
    trial = {rem_q, shf_q[QW-1]};
    diff  = {1'b0, trial} - {2'b00, dvs_q};
    fits  = ~diff[QW+1];
  end

  always_comb begin
    reg_en = load_i | step_i;
    rem_d  = rem_q;
    shf_d  = shf_q;
    dvs_d  = dvs_q;
    cnt_d  = cnt_q;
    if (load_i) begin
      rem_d = dvd_mag_i[DW-1:QW];
      shf_d = dvd_mag_i[QW-1:0];
      dvs_d = dvs_mag_i;
      cnt_d = '0;
    end else if (step_i) begin
      rem_d = fits ? diff[QW-1:0] : trial[QW-1:0];
      shf_d = {shf_q[QW-2:0], fits};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      shf_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (reg_en) begin
      rem_q <= rem_d;
      shf_q <= shf_d;
      dvs_q <= dvs_d;
      cnt_q <= cnt_d;
    end
  end

  assign quo_mag_o = shf_q;
  assign rem_mag_o = rem_q;
  assign last_o    = (cnt_q == LAST_CNT);

  // R2: the iteration count advances by exactly one per step
  a_r2_cnt_step : assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && !last_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R2: a new operation always restarts the count
  a_r2_cnt_load : assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == '0));

endmodule

// File: rtl/seq_div_fix.sv
// Sign correction and range check applied after the last iteration.
module seq_div_fix #(
  parameter int QW = 16,
  parameter int SW = 8
) (
  input  logic          sgn_i,
  input  logic          word_i,
  input  logic          dvd_neg_i,
  input  logic          dvs_neg_i,
  input  logic          pre_ovf_i,
  input  logic [QW-1:0] quo_mag_i,
  input  logic [QW-1:0] rem_mag_i,
  output logic [QW-1:0] quo_o,
  output logic [QW-1:0] rem_o,
  output logic          ovf_o
);

  localparam logic [QW:0] ONE        = (QW+1)'(1);
  localparam logic [QW:0] LIM_U_WORD = (ONE << QW) - ONE;
  localparam logic [QW:0] LIM_U_BYTE = (ONE << SW) - ONE;
  localparam logic [QW:0] LIM_N_WORD = ONE << (QW - 1);
  localparam logic [QW:0] LIM_N_BYTE = ONE << (SW - 1);

  logic        q_neg;
  logic [QW:0] limit;

  always_comb begin
    q_neg = sgn_i & (dvd_neg_i ^ dvs_neg_i);
    if (sgn_i) begin
      limit = (word_i ? LIM_N_WORD : LIM_N_BYTE) - (q_neg ? '0 : ONE);
    end else begin
      limit = word_i ? LIM_U_WORD : LIM_U_BYTE;
    end
    quo_o = q_neg ? (~quo_mag_i + 1'b1) : quo_mag_i;
    rem_o = dvd_neg_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
    ovf_o = pre_ovf_i | ({1'b0, quo_mag_i} > limit);
  end

endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int QW = 16,
  parameter int SW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            signed_i,
  input  logic            word_i,
  input  logic [2*QW-1:0] dividend_i,
  input  logic [QW-1:0]   divisor_i,
  output logic [QW-1:0]   quotient_o,
  output logic [QW-1:0]   remainder_o,
  output logic            overflow_o,
  output logic            done_o
);

  import seq_div_pkg::*;

  localparam int DW = 2 * QW;

  div_state_e state_q, state_d;

  logic accept;
  logic running;
  logic finishing;
  logic last;

  logic [DW-1:0] dvd_mag;
  logic [QW-1:0] dvs_mag;
  logic          dvd_neg, dvs_neg, dvs_zero, hi_ovf;

  logic sgn_q, word_q, dvd_neg_q, dvs_neg_q, zero_q, pre_ovf_q;

  logic [QW-1:0] quo_mag, rem_mag;
  logic [QW-1:0] fix_quo, fix_rem;
  logic          fix_ovf;

  logic [QW-1:0] quotient_q, remainder_q;
  logic          ovf_q, done_q, done_d;

  seq_div_prep #(.QW(QW), .SW(SW)) u_prep (
    .signed_i   (signed_i),
    .word_i     (word_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .dvd_mag_o  (dvd_mag),
    .dvs_mag_o  (dvs_mag),
    .dvd_neg_o  (dvd_neg),
    .dvs_neg_o  (dvs_neg),
    .dvs_zero_o (dvs_zero),
    .hi_ovf_o   (hi_ovf)
  );

  seq_div_core #(.QW(QW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (accept),
    .step_i    (running),
    .dvd_mag_i (dvd_mag),
    .dvs_mag_i (dvs_mag),
    .quo_mag_o (quo_mag),
    .rem_mag_o (rem_mag),
    .last_o    (last)
  );

  seq_div_fix #(.QW(QW), .SW(SW)) u_fix (
    .sgn_i     (sgn_q),
    .word_i    (word_q),
    .dvd_neg_i (dvd_neg_q),
    .dvs_neg_i (dvs_neg_q),
    .pre_ovf_i (pre_ovf_q),
    .quo_mag_i (quo_mag),
    .rem_mag_i (rem_mag),
    .quo_o     (fix_quo),
    .rem_o     (fix_rem),
    .ovf_o     (fix_ovf)
  );

  // Next-state logic
  always_comb begin
    accept    = (state_q == ST_IDLE) && start_i;
    running   = (state_q == ST_RUN);
    finishing = (state_q == ST_FIN);
    done_d    = finishing;
    state_d   = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN:  if (last)    state_d = ST_FIN;
      ST_FIN:               state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  // State and pulse registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  // Operand-side control captured on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sgn_q     <= 1'b0;
      word_q    <= 1'b0;
      dvd_neg_q <= 1'b0;
      dvs_neg_q <= 1'b0;
      zero_q    <= 1'b0;
      pre_ovf_q <= 1'b0;
    end else if (accept) begin
      sgn_q     <= signed_i;
      word_q    <= word_i;
      dvd_neg_q <= dvd_neg;
      dvs_neg_q <= dvs_neg;
      zero_q    <= dvs_zero;
      pre_ovf_q <= dvs_zero | hi_ovf;
    end
  end

  // Result registers, loaded only in the correction cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quotient_q  <= '0;
      remainder_q <= '0;
      ovf_q       <= 1'b0;
    end else if (finishing) begin
      quotient_q  <= fix_quo;
      remainder_q <= fix_rem;
      ovf_q       <= fix_ovf;
    end
  end

  assign quotient_o  = quotient_q;
  assign remainder_o = remainder_q;
  assign overflow_o  = ovf_q;
  assign done_o      = done_q;

  // R2: done is a single-cycle pulse
  a_r2_done_single : assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R2: done only ever follows the correction state
  a_r2_done_after_fin : assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(state_q) == ST_FIN));

  // R6: a zero divisor always completes with overflow
  a_r6_zero_overflow : assert property (@(posedge clk) disable iff (!rst_n)
    (finishing && zero_q) |=> (done_q && ovf_q));

  // R7: an unsigned byte quotient that fits has a clear upper part
  a_r7_byte_fits : assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !ovf_q && !sgn_q && !word_q) |-> (quotient_q[QW-1:SW] == '0));

  // R4: a nonzero signed remainder carries the dividend's sign
  a_r4_rem_sign : assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !ovf_q && sgn_q && (remainder_q != '0)) |-> (remainder_q[QW-1] == dvd_neg_q));

  // R8: a start during an operation leaves the captured control untouched
  a_r8_busy_ignore : assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != ST_IDLE) && start_i) |=> ($stable(sgn_q) && $stable(word_q) && $stable(pre_ovf_q)));

endmodule

// File: tb/seq_divider_tb_top.sv
module seq_divider_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        signed_i;
  logic        word_i;
  logic [31:0] dividend_i;
  logic [15:0] divisor_i;
  logic [15:0] quotient_o;
  logic [15:0] remainder_o;
  logic        overflow_o;
  logic        done_o;

  seq_divider dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .signed_i    (signed_i),
    .word_i      (word_i),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o),
    .overflow_o  (overflow_o),
    .done_o      (done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    n_chk  = 0;
  int    n_fail = 0;
  int    cyc    = 0;
  string cur_tag = "R1";

  // Behavioural model state
  bit          m_busy;
  int          m_cnt;
  bit          m_done;
  logic [15:0] m_q, m_r;
  bit          m_ov;
  bit          p_sg, p_wd;
  logic [31:0] p_a;
  logic [15:0] p_b;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  function automatic void ref_div(input bit sg, input bit wd, input logic [31:0] a,
                                  input logic [15:0] b, output logic [15:0] q,
                                  output logic [15:0] r, output bit ov);
    longint av, bv, qv, rv, lo, hi;
    av = sg ? {{32{a[31]}}, a} : {32'b0, a};
    if (wd) bv = sg ? {{48{b[15]}}, b} : {48'b0, b};
    else    bv = sg ? {{56{b[7]}}, b[7:0]} : {56'b0, b[7:0]};
    if (bv == 0) begin
      q = '0; r = '0; ov = 1'b1;
    end else begin
      qv = av / bv;
      rv = av % bv;
      if (sg) begin lo = wd ? -32768 : -128; hi = wd ? 32767 : 127; end
      else    begin lo = 0;                  hi = wd ? 65535 : 255; end
      ov = (qv < lo) || (qv > hi);
      q  = qv[15:0];
      r  = rv[15:0];
    end
  endfunction

  // Reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_cnt = 0; m_done = 1'b0;
      m_q = '0; m_r = '0; m_ov = 1'b0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 1'b0;
          m_done = 1'b1;
          ref_div(p_sg, p_wd, p_a, p_b, m_q, m_r, m_ov);
        end
      end else if (start_i) begin
        m_busy = 1'b1;
        m_cnt  = 17;
        p_sg = signed_i; p_wd = word_i; p_a = dividend_i; p_b = divisor_i;
      end
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(done_o === m_done, "R2", "done_o", {31'b0, done_o}, {31'b0, m_done});
      chk(overflow_o === m_ov, m_done ? cur_tag : "R9", "overflow_o",
          {31'b0, overflow_o}, {31'b0, m_ov});
      if (!m_ov) begin
        chk(quotient_o === m_q, m_done ? cur_tag : "R9", "quotient_o",
            {16'b0, quotient_o}, {16'b0, m_q});
        chk(remainder_o === m_r, m_done ? cur_tag : "R9", "remainder_o",
            {16'b0, remainder_o}, {16'b0, m_r});
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic run_op(input string tag, input bit sg, input bit wd,
                        input logic [31:0] a, input logic [15:0] b);
    @(negedge clk);
    cur_tag    = tag;
    signed_i   = sg;
    word_i     = wd;
    dividend_i = a;
    divisor_i  = b;
    start_i    = 1'b1;
    @(negedge clk);
    start_i    = 1'b0;
    // R9: scramble the operands after capture
    signed_i   = ~sg;
    word_i     = ~wd;
    dividend_i = 32'h5A5A_C3C3;
    divisor_i  = 16'h0003;
    while (!m_done) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; signed_i = 1'b0; word_i = 1'b1;
    dividend_i = '0; divisor_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state while held
    chk(done_o === 1'b0 && overflow_o === 1'b0, "R1", "flags in reset",
        {30'b0, done_o, overflow_o}, 32'h0);
    chk(quotient_o === 16'h0 && remainder_o === 16'h0, "R1", "results in reset",
        {quotient_o, remainder_o}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(done_o === 1'b0 && quotient_o === 16'h0, "R1", "after release",
        {15'b0, done_o, quotient_o}, 32'h0);

    // R3: unsigned word
    run_op("R3", 0, 1, 32'd1000, 16'd7);
    run_op("R3", 0, 1, 32'h0012_3456, 16'h1234);
    run_op("R3", 0, 1, 32'd5, 16'd9);
    run_op("R3", 0, 1, 32'hFFFE_0001, 16'hFFFF);
    // R3: decimal split, 8-bit value / 10 in byte mode
    run_op("R3", 0, 0, 32'd219, 16'd10);
    run_op("R3", 0, 0, 32'd9, 16'd10);

    // R4: signed word, every sign combination
    run_op("R4", 1, 1, -32'sd1000, 16'd7);
    run_op("R4", 1, 1, 32'd1000, -16'sd7);
    run_op("R4", 1, 1, -32'sd1000, -16'sd7);
    run_op("R4", 1, 1, -32'sd6, 16'd3);

    // R5: byte mode ignores the upper divisor byte
    run_op("R5", 0, 0, 32'd200, 16'hAB07);
    run_op("R5", 1, 0, -32'sd100, 16'h12FD);
    run_op("R5", 1, 0, 32'd100, 16'h7703);

    // R6: zero divisor, including a zero low byte in byte mode
    run_op("R6", 0, 1, 32'd1234, 16'h0000);
    run_op("R6", 1, 0, 32'd50, 16'hFF00);

    // R7: range boundaries
    run_op("R7", 0, 1, 32'h0000_FFFF, 16'd1);
    run_op("R7", 0, 1, 32'h0001_0000, 16'd1);
    run_op("R7", 0, 0, 32'd255, 16'd1);
    run_op("R7", 0, 0, 32'd256, 16'd1);
    run_op("R7", 1, 1, 32'hFFFF_8000, 16'd1);
    run_op("R7", 1, 1, 32'h0000_8000, 16'd1);
    run_op("R7", 1, 0, 32'hFFFF_FF80, 16'h0001);
    run_op("R7", 1, 0, 32'h0000_0080, 16'h0001);
    run_op("R7", 1, 0, 32'd127, 16'h00FF);

    // R8: a second start during the operation is ignored
    @(negedge clk);
    cur_tag = "R8";
    signed_i = 1'b0; word_i = 1'b1; dividend_i = 32'd777; divisor_i = 16'd5;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    dividend_i = 32'd9; divisor_i = 16'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!m_done) @(negedge clk);
    repeat (25) @(negedge clk);

    // R2: back-to-back request immediately after completion
    run_op("R2", 0, 1, 32'd4096, 16'd64);
    run_op("R2", 1, 1, -32'sd4096, 16'd64);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule